// File: doc/BRIEF.md
# Flash Embedded-Operation Status Bit Generator

This block sits on the device side of a multi-bank flash array. For each bank it decides what a host read returns: true array data, or a status word. A status word carries a progress flag on bit 7 and a flip-flop on bit 6 that inverts with every read. The block counts the write pulses of each command sequence to decide when a program or erase begins. It keeps the bit 7 of the last programmed byte, and it follows each bank through program, erase time-out, erase, erase suspend and program-during-suspend. An external array engine reports the phase changes over a small control port.

When the target sector of a program, or every sector chosen for an erase, is protected, no array engine is involved. The bank reports status for a fixed window counted in clock cycles and then returns to array reads by itself. The read strobe is asynchronous and active low, formed outside from chip enable and output enable. It is synchronized, and each falling edge advances the bit-6 flip-flop of the addressed bank exactly once.

Top module: `fsb_status_gen`

## Requirements
- R1: After reset every bank is idle, and a read of any bank returns `array_data` unchanged.
- R2: A sequence of four write pulses with `wr_erase`=0 starts a program. Three pulses are not enough, and reads then still return array data. Once the fourth pulse is taken, reads return bit 7 equal to the complement of bit 7 of the data on the fourth pulse, with bits DW-3..0 at zero.
- R3: A sequence of six write pulses with `wr_erase`=1 starts the erase time-out. Five pulses are not enough. Bit 7 reads 0 both in the time-out and in the erase that follows `ctl_op`=0 (begin erase).
- R4: Bit 6 reads 1 on the first status read after a sequence started from idle. It inverts on each falling edge of `rd_n` addressed to that bank during program, time-out, erase, program-during-suspend and the protected hold.
- R5: `ctl_op`=1 (done) returns a programming or erasing bank to array reads.
- R6: A program sequence whose final pulse carries `wr_prot`=1 reports status for PROT_PROG_CYC cycles, then returns to array reads with no done command.
- R7: An erase sequence whose final pulse carries `wr_prot`=1 reports status (bit 7 = 0) for PROT_ERASE_CYC cycles, then returns to array reads.
- R8: `ctl_op`=2 (suspend) during erase freezes bit 6 while bit 7 stays 0. `ctl_op`=3 (resume) brings back erase with toggling.
- R9: While a bank is suspended, a four-pulse program sequence starts a program-during-suspend. In that state bit 7 is the complement of the new data, bit 6 toggles again, and done returns the bank to the suspended state.
- R10: Banks are independent: another bank's reads return array data while one bank is busy. Write pulses to a programming bank are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_pulse | input | 1 | One-cycle strobe per command write pulse |
| wr_bank | input | BW | Bank addressed by the write pulse |
| wr_erase | input | 1 | 1 = pulse belongs to a six-pulse erase sequence, 0 = four-pulse program |
| wr_prot | input | 1 | Target sector protected (program) or all selected sectors protected (erase) |
| wr_data | input | DW | Data carried by the write pulse |
| ctl_valid | input | 1 | Array engine control strobe |
| ctl_bank | input | BW | Bank addressed by the control strobe |
| ctl_op | input | 2 | 0 begin erase, 1 done, 2 suspend, 3 resume |
| rd_n | input | 1 | Asynchronous active-low read strobe |
| rd_bank | input | BW | Bank being read |
| array_data | input | DW | True data from the array |
| rd_data | output | DW | Data returned to the host |

## Verification
Program sequences are run with data bit 7 set and with it clear, so that a true bit cannot pass for a complemented one. They are also run with a pulse short of the required count, which shows that status starts on the right pulse. Erase is walked through time-out, erase, suspend, program-during-suspend and resume, reading several times in each phase. This separates a frozen bit 6 from a toggling one, and shows that the toggle keeps its phase across phase changes. Protected program and protected erase are read at a time between their two windows, which shows that each uses its own length. A second bank is read while the first is busy to expose any leak between banks.

// File: rtl/fsb_status_pkg.sv
package fsb_status_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PROG  = 3'd1,
      ST_ERTO  = 3'd2,
      ST_ERASE = 3'd3,
      ST_SUSP  = 3'd4,
      ST_SPROG = 3'd5,
      ST_PROT  = 3'd6
   } bank_st_t;

   typedef enum logic [1:0] {
      CT_GO     = 2'd0,
      CT_DONE   = 2'd1,
      CT_SUSP   = 2'd2,
      CT_RESUME = 2'd3
   } ctl_op_t;

   localparam int unsigned PROG_PULSES  = 4;
   localparam int unsigned ERASE_PULSES = 6;

endpackage

// File: rtl/fsb_rdsync.sv
module fsb_rdsync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_n_i,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fsb_rdsync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              lvl_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q       <= '1;
         lvl_prev_q <= 1'b1;
      end else begin
         sh_q       <= {sh_q[STAGES-2:0], rd_n_i};
         lvl_prev_q <= sh_q[STAGES-1];
      end
   end

   assign fall_o = lvl_prev_q & ~sh_q[STAGES-1];

endmodule

// File: rtl/fsb_bank.sv
module fsb_bank
   import fsb_status_pkg::*;
#(
   parameter int unsigned PROT_PROG_CYC  = 250,
   parameter int unsigned PROT_ERASE_CYC = 100000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_hit_i,
   input  logic       wr_erase_i,
   input  logic       wr_prot_i,
   input  logic       wr_d7_i,
   input  logic       ctl_hit_i,
   input  logic [1:0] ctl_op_i,
   input  logic       rd_fall_i,
   output logic       stat_o,
   output logic       dq7_o,
   output logic       dq6_o
);
   localparam int unsigned MAXC = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC;
   localparam int unsigned TW   = $clog2(MAXC + 1);

   if (PROT_PROG_CYC < 1 || PROT_ERASE_CYC < 1) begin : g_bad_win
      $error("fsb_bank: protected windows must be at least one cycle");
   end

   bank_st_t       st_q, st_d;
   logic [TW-1:0]  tmr_q, tmr_d;
   logic [2:0]     cnt_q;
   logic           kind_q, d7_q, tgl_q;
   logic           accept, last, toggling;
   logic [2:0]     need;
   ctl_op_t        op;

   assign op       = ctl_op_t'(ctl_op_i);
   assign need     = (wr_erase_i && st_q == ST_IDLE) ? 3'(ERASE_PULSES) : 3'(PROG_PULSES);
   assign accept   = wr_hit_i && (st_q == ST_IDLE || (st_q == ST_SUSP && !wr_erase_i));
   assign last     = accept && (cnt_q + 3'd1 == need);
   assign toggling = (st_q == ST_PROG) || (st_q == ST_ERTO) || (st_q == ST_ERASE) ||
                     (st_q == ST_SPROG) || (st_q == ST_PROT);

   always_comb begin
      st_d  = st_q;
      tmr_d = tmr_q;
      unique case (st_q)
         ST_IDLE: if (last) begin
            if (wr_prot_i) begin
               st_d  = ST_PROT;
               tmr_d = wr_erase_i ? TW'(PROT_ERASE_CYC) : TW'(PROT_PROG_CYC);
            end else begin
               st_d = wr_erase_i ? ST_ERTO : ST_PROG;
            end
         end
         ST_PROG:  if (ctl_hit_i && op == CT_DONE) st_d = ST_IDLE;
         ST_ERTO: if (ctl_hit_i) begin
            if (op == CT_GO)        st_d = ST_ERASE;
            else if (op == CT_DONE) st_d = ST_IDLE;
         end
         ST_ERASE: if (ctl_hit_i) begin
            if (op == CT_DONE)      st_d = ST_IDLE;
            else if (op == CT_SUSP) st_d = ST_SUSP;
         end
         ST_SUSP: begin
            if (last)                                st_d = ST_SPROG;
            else if (ctl_hit_i && op == CT_RESUME)   st_d = ST_ERASE;
         end
         ST_SPROG: if (ctl_hit_i && op == CT_DONE) st_d = ST_SUSP;
         ST_PROT: begin
            tmr_d = tmr_q - TW'(1);
            if (tmr_q == TW'(1)) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         tmr_q  <= '0;
         cnt_q  <= '0;
         kind_q <= 1'b0;
         d7_q   <= 1'b0;
         tgl_q  <= 1'b0;
      end else begin
         st_q  <= st_d;
         tmr_q <= tmr_d;
         if (accept) cnt_q <= last ? 3'd0 : cnt_q + 3'd1;
         if (last) begin
            kind_q <= wr_erase_i;
            if (!wr_erase_i) d7_q <= wr_d7_i;
         end
         if (last && st_q == ST_IDLE)       tgl_q <= 1'b0;
         else if (rd_fall_i && toggling)    tgl_q <= ~tgl_q;
      end
   end

   assign stat_o = (st_q != ST_IDLE);
   assign dq7_o  = (st_q == ST_PROG || st_q == ST_SPROG || (st_q == ST_PROT && !kind_q)) ? ~d7_q : 1'b0;
   assign dq6_o  = tgl_q;

   // R4
   tgl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(tgl_q) |-> ($past(rd_fall_i) || $past(st_q) == ST_IDLE));
   // R8
   susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SUSP) |=> $stable(tgl_q));
   // R6
   prot_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PROT) |=> (st_q == ST_PROT || st_q == ST_IDLE));
   // R7
   tmr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PROT) |-> (tmr_q != '0));
   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PROG && wr_hit_i) |=> $stable(d7_q));

endmodule

// File: rtl/fsb_status_gen.sv
module fsb_status_gen
   import fsb_status_pkg::*;
#(
   parameter int unsigned NBANKS         = 2,
   parameter int unsigned DW             = 8,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned PROT_PROG_CYC  = 250,
   parameter int unsigned PROT_ERASE_CYC = 100000,
   localparam int unsigned BW            = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_pulse,
   input  logic [BW-1:0] wr_bank,
   input  logic          wr_erase,
   input  logic          wr_prot,
   input  logic [DW-1:0] wr_data,
   input  logic          ctl_valid,
   input  logic [BW-1:0] ctl_bank,
   input  logic [1:0]    ctl_op,
   input  logic          rd_n,
   input  logic [BW-1:0] rd_bank,
   input  logic [DW-1:0] array_data,
   output logic [DW-1:0] rd_data
);
   if (NBANKS < 2) begin : g_bad_banks
      $error("fsb_status_gen: NBANKS must be at least 2");
   end
   if (DW < 8) begin : g_bad_dw
      $error("fsb_status_gen: DW must be at least 8");
   end

   logic              rd_fall;
   logic [NBANKS-1:0] stat, dq7, dq6;

   fsb_rdsync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_n_i (rd_n),
      .fall_o (rd_fall)
   );

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      fsb_bank #(
         .PROT_PROG_CYC  (PROT_PROG_CYC),
         .PROT_ERASE_CYC (PROT_ERASE_CYC)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_hit_i   (wr_pulse && wr_bank == BW'(b)),
         .wr_erase_i (wr_erase),
         .wr_prot_i  (wr_prot),
         .wr_d7_i    (wr_data[7]),
         .ctl_hit_i  (ctl_valid && ctl_bank == BW'(b)),
         .ctl_op_i   (ctl_op),
         .rd_fall_i  (rd_fall && rd_bank == BW'(b)),
         .stat_o     (stat[b]),
         .dq7_o      (dq7[b]),
         .dq6_o      (dq6[b])
      );
   end

   always_comb begin
      rd_data = array_data;
      for (int b = 0; b < NBANKS; b++) begin
         if (rd_bank == BW'(b) && stat[b])
            rd_data = {dq7[b], dq6[b], {(DW-2){1'b0}}};
      end
   end

endmodule

// File: tb/fsb_status_gen_tb.sv
module fsb_status_gen_tb;
   localparam int unsigned NB = 2;
   localparam int unsigned DW = 8;
   localparam int unsigned PP = 40;
   localparam int unsigned PE = 120;
   localparam logic [7:0]  ARR = 8'h3C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_pulse = 1'b0, wr_erase = 1'b0, wr_prot = 1'b0;
   logic [0:0]    wr_bank = '0, ctl_bank = '0, rd_bank = '0;
   logic [DW-1:0] wr_data = '0;
   logic          ctl_valid = 1'b0;
   logic [1:0]    ctl_op = '0;
   logic          rd_n = 1'b1;
   logic [DW-1:0] array_data = ARR;
   logic [DW-1:0] rd_data;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   fsb_status_gen #(
      .NBANKS(NB), .DW(DW), .SYNC_STAGES(2),
      .PROT_PROG_CYC(PP), .PROT_ERASE_CYC(PE)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_bank(wr_bank),
      .wr_erase(wr_erase), .wr_prot(wr_prot), .wr_data(wr_data),
      .ctl_valid(ctl_valid), .ctl_bank(ctl_bank), .ctl_op(ctl_op),
      .rd_n(rd_n), .rd_bank(rd_bank), .array_data(array_data), .rd_data(rd_data)
   );

   task automatic wr(input int b, input logic er, input logic pr, input logic [7:0] d);
      @(negedge clk);
      wr_pulse = 1'b1; wr_bank = b[0:0]; wr_erase = er; wr_prot = pr; wr_data = d;
      @(negedge clk);
      wr_pulse = 1'b0; wr_prot = 1'b0;
   endtask

   task automatic wr_n(input int b, input logic er, input logic pr, input logic [7:0] d, input int n);
      for (int i = 0; i < n; i++) wr(b, er, (i == n - 1) ? pr : 1'b0, d);
   endtask

   task automatic ctl(input int b, input logic [1:0] op);
      @(negedge clk);
      ctl_valid = 1'b1; ctl_bank = b[0:0]; ctl_op = op;
      @(negedge clk);
      ctl_valid = 1'b0;
   endtask

   task automatic rd_expect(input int b, input logic [7:0] exp, input string req);
      logic [7:0] got;
      @(negedge clk);
      rd_bank = b[0:0]; rd_n = 1'b0;
      repeat (6) @(negedge clk);
      got = rd_data;
      rd_n = 1'b1;
      repeat (4) @(negedge clk);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: bank %0d read %h expected %h", req, b, got, exp);
      end
   endtask

   task automatic t_reset();
      rd_expect(0, ARR, "R1");
      rd_expect(1, ARR, "R1");
   endtask

   task automatic t_program();
      wr_n(0, 1'b0, 1'b0, 8'h5A, 3);
      rd_expect(0, ARR, "R2 three pulses");
      wr(0, 1'b0, 1'b0, 8'h5A);
      rd_expect(0, 8'hC0, "R2 R4 first read");
      rd_expect(0, 8'h80, "R4 second read");
      rd_expect(1, ARR, "R10 other bank");
      wr_n(0, 1'b0, 1'b0, 8'hFF, 4);
      rd_expect(0, 8'hC0, "R10 busy ignore");
      ctl(0, 2'd1);
      rd_expect(0, ARR, "R5 program done");
      wr_n(0, 1'b0, 1'b0, 8'hA5, 4);
      rd_expect(0, 8'h40, "R2 data bit7 set");
      ctl(0, 2'd1);
      rd_expect(0, ARR, "R5");
   endtask

   task automatic t_erase();
      wr_n(1, 1'b1, 1'b0, 8'h00, 5);
      rd_expect(1, ARR, "R3 five pulses");
      wr(1, 1'b1, 1'b0, 8'h00);
      rd_expect(1, 8'h40, "R3 R4 time-out");
      rd_expect(1, 8'h00, "R3 R4 time-out toggle");
      ctl(1, 2'd0);
      rd_expect(1, 8'h40, "R3 erase");
      ctl(1, 2'd2);
      rd_expect(1, 8'h40, "R8 suspend frozen");
      rd_expect(1, 8'h40, "R8 suspend frozen again");
      wr_n(1, 1'b0, 1'b0, 8'h11, 4);
      rd_expect(1, 8'h80, "R9 suspend program");
      rd_expect(1, 8'hC0, "R9 suspend program toggle");
      ctl(1, 2'd1);
      rd_expect(1, 8'h40, "R9 back to suspend");
      rd_expect(1, 8'h40, "R9 R8 frozen");
      ctl(1, 2'd3);
      rd_expect(1, 8'h00, "R8 resume toggles");
      ctl(1, 2'd1);
      rd_expect(1, ARR, "R5 erase done");
   endtask

   task automatic t_prot_prog();
      wr_n(0, 1'b0, 1'b1, 8'h00, 4);
      rd_expect(0, 8'hC0, "R6 protected status");
      rd_expect(0, 8'h80, "R6 R4 toggle");
      repeat (PP) @(negedge clk);
      rd_expect(0, ARR, "R6 self return");
   endtask

   task automatic t_prot_erase();
      wr_n(0, 1'b1, 1'b1, 8'h00, 6);
      rd_expect(0, 8'h40, "R7 protected status");
      repeat (50) @(negedge clk);
      rd_expect(0, 8'h00, "R7 longer window");
      repeat (PE) @(negedge clk);
      rd_expect(0, ARR, "R7 self return");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_program();
      t_erase();
      t_prot_prog();
      t_prot_erase();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule